// File: doc/BRIEF.md
# Indirect-Addressed GPIO Port Controller

This block is one parallel general-purpose I/O port, by default eight bits wide. The CPU reaches it through a small synchronous register bus that has four direct locations: output data, input data, an index register and a control window. The pin configuration sits behind the control window. Software first writes a sub-register code into the index register. Each later read or write of the control window then reaches the sub-register that code selects. Two codes are implemented: one for the per-pin direction bits and one for the per-pin alternate-function enables.

On the pad side, every bit has three signals: a driven value, an active-high output enable for a tristate pad, and a raw input. A peripheral that owns a pin supplies its own output value and output enable for that pin. When the alternate-function enable for the pin is set, those signals replace the GPIO settings. Raw pad inputs pass through a two-flop synchronizer and then into the input data register, which is read-only.

Top module: `gpio_idx_port`

## Requirements
- R1: After reset, the index register reads 00h, output data reads 00h, every direction bit reads 1, every alternate-function enable reads 0, and every `pad_oe` bit is 0.
- R2: The bus decodes `bus_addr` as 0 = output data (read/write), 1 = input data (read-only), 2 = index register (read/write), 3 = control window. A write takes effect at the rising clock edge when `bus_sel` and `bus_wr` are high. Read data is combinational and is 0 while `bus_sel` is low.
- R3: With index code 01h, the control window reads and writes the direction bits. With index code 02h, it reads and writes the alternate-function enables.
- R4: With any other index code, a control-window read returns 00h and a control-window write changes no register.
- R5: A pin whose alternate-function enable is 0 and whose direction bit is 0 is an output: `pad_oe` is 1 and `pad_out` equals that bit of output data.
- R6: A pin whose alternate-function enable is 0 and whose direction bit is 1 is an input: `pad_oe` is 0.
- R7: A pin whose alternate-function enable is 1 drives `pad_out` from `af_out` and `pad_oe` from `af_oe`, whatever its direction bit holds.
- R8: Input data shows the value `pad_in` held three rising edges earlier: two synchronizer flops and then the register. A change of `pad_in` before edge k can first be read after edge k+2.
- R9: A bus write to the input data location changes no register, and input data keeps following `pad_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Direct register location |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data |
| pad_in | input | W | Raw pad inputs |
| pad_out | output | W | Value to drive on each pad |
| pad_oe | output | W | Per-pad output enable, active high |
| af_out | input | W | Alternate-function output values |
| af_oe | input | W | Alternate-function output enables |

## Verification
The pad mux is tested with direction patterns of all outputs, all inputs and a split nibble. This shows whether `pad_oe` tracks the inverted direction bits and whether `pad_out` comes from output data. Next, an alternate-function mask set over a mixed direction pattern is given `af_oe` and `af_out` values that differ from the GPIO values. This separates override bits from GPIO bits on both outputs. The bench tries index codes 00h, 03h and FFh and checks both that they read as zero and that they leave direction and enables untouched. An input word changes and is read after exactly two and exactly three edges, which pins down the synchronizer depth.

// File: rtl/gpio_idx_pkg.sv
package gpio_idx_pkg;

  typedef enum logic [1:0] {
    LOC_OUT = 2'd0,
    LOC_IN  = 2'd1,
    LOC_IDX = 2'd2,
    LOC_CTL = 2'd3
  } port_loc_e;

  localparam int SUB_DIR_CODE = 1;
  localparam int SUB_ALT_CODE = 2;

  // pick the GPIO or alternate value per bit
  function automatic logic pick_bit(input logic alt, input logic af_v, input logic gp_v);
    return alt ? af_v : gp_v;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] in_q
);
  localparam int DEPTH = 3;
  localparam int AGE_W = $clog2(DEPTH + 1);

  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      in_q <= '0;
    end else begin
      s1_q <= pad_in;
      s2_q <= s1_q;
      in_q <= s2_q;
    end
  end

  // cycles since reset, saturating, so the latency check looks back only over clean history
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else if (age_q != AGE_W'(DEPTH)) age_q <= age_q + 1'b1;
  end

  // R8
  in_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == AGE_W'(DEPTH)) |-> (in_q == $past(pad_in, 3)));

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_idx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  input  logic [W-1:0] in_q,
  output logic [W-1:0] bus_rdata,
  output logic [W-1:0] out_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] alt_q
);
  localparam logic [W-1:0] DIR_CODE = W'(SUB_DIR_CODE);
  localparam logic [W-1:0] ALT_CODE = W'(SUB_ALT_CODE);

  logic [W-1:0] idx_q;

  // named access events
  logic wr_any, wr_out, wr_in, wr_idx, wr_ctl;
  logic hit_dir, hit_alt, hit_none;

  assign wr_any   = bus_sel & bus_wr;
  assign wr_out   = wr_any && (bus_addr == LOC_OUT);
  assign wr_in    = wr_any && (bus_addr == LOC_IN);
  assign wr_idx   = wr_any && (bus_addr == LOC_IDX);
  assign wr_ctl   = wr_any && (bus_addr == LOC_CTL);
  assign hit_dir  = (idx_q == DIR_CODE);
  assign hit_alt  = (idx_q == ALT_CODE);
  assign hit_none = !(hit_dir || hit_alt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      out_q <= '0;
      dir_q <= '1;
      alt_q <= '0;
    end else begin
      if (wr_out) out_q <= bus_wdata;
      if (wr_idx) idx_q <= bus_wdata;
      if (wr_ctl && hit_dir) dir_q <= bus_wdata;
      if (wr_ctl && hit_alt) alt_q <= bus_wdata;
    end
  end

  function automatic logic [W-1:0] window_read(input logic dsel, input logic asel,
                                                input logic [W-1:0] d, input logic [W-1:0] a);
    if (dsel) return d;
    if (asel) return a;
    return '0;
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (port_loc_e'(bus_addr))
        LOC_OUT: bus_rdata = out_q;
        LOC_IN:  bus_rdata = in_q;
        LOC_IDX: bus_rdata = idx_q;
        LOC_CTL: bus_rdata = window_read(hit_dir, hit_alt, dir_q, alt_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  // R1
  rst_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dir_q == '1 && alt_q == '0 && idx_q == '0 && out_q == '0));

  // R4
  bad_code_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && hit_none) |=> ($stable(dir_q) && $stable(alt_q)));

  // R9
  in_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_in |=> ($stable(dir_q) && $stable(alt_q) && $stable(idx_q) && $stable(out_q)));

  // R3
  dir_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && hit_dir) |=> (dir_q == $past(bus_wdata)));

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_idx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] out_q,
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] alt_q,
  input  logic [W-1:0] af_out,
  input  logic [W-1:0] af_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign pad_out[i] = pick_bit(alt_q[i], af_out[i], out_q[i]);
    assign pad_oe[i]  = pick_bit(alt_q[i], af_oe[i], ~dir_q[i]);
  end

  // R6
  input_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & dir_q & ~alt_q) == '0));

  // R5
  output_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((~pad_oe | (pad_out ^ out_q)) & ~dir_q & ~alt_q) == '0));

  // R7
  alt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((((pad_oe ^ af_oe) | (pad_out ^ af_out)) & alt_q) == '0));

endmodule

// File: rtl/gpio_idx_port.sv
module gpio_idx_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe,
  input  logic [W-1:0] af_out,
  input  logic [W-1:0] af_oe
);
  logic [W-1:0] in_q, out_q, dir_q, alt_q;

  gpio_in_sync #(.W(W)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .in_q(in_q)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .in_q(in_q), .bus_rdata(bus_rdata),
    .out_q(out_q), .dir_q(dir_q), .alt_q(alt_q)
  );

  gpio_pad_mux #(.W(W)) u_mux (
    .clk(clk), .rst_n(rst_n),
    .out_q(out_q), .dir_q(dir_q), .alt_q(alt_q),
    .af_out(af_out), .af_oe(af_oe),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

endmodule

// File: tb/sim_gpio_idx_port.sv
module sim_gpio_idx_port;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;
  localparam logic [1:0] A_OUT = 2'd0, A_IN = 2'd1, A_IDX = 2'd2, A_CTL = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [W-1:0] bus_wdata = '0, pad_in = '0, af_out = '0, af_oe = '0;
  logic [W-1:0] bus_rdata, pad_out, pad_oe;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_idx_port #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .af_out(af_out), .af_oe(af_oe)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic sub_rd(input logic [W-1:0] code, output logic [W-1:0] d);
    wr(A_IDX, code);
    rd(A_CTL, d);
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    rd(A_OUT, v); chk("R1 out", v, 8'h00);
    rd(A_IDX, v); chk("R1 idx", v, 8'h00);
    chk("R1 oe", pad_oe, 8'h00);
    sub_rd(8'h01, v); chk("R1 dir", v, 8'hFF);
    sub_rd(8'h02, v); chk("R1 alt", v, 8'h00);
    #1 chk("R2 idle rdata", bus_rdata, 8'h00);
  endtask

  task automatic t_index();
    logic [W-1:0] v;
    wr(A_IDX, 8'h5A); rd(A_IDX, v); chk("R2 idx rw", v, 8'h5A);
    wr(A_OUT, 8'hA5); rd(A_OUT, v); chk("R2 out rw", v, 8'hA5);
  endtask

  task automatic t_dir();
    logic [W-1:0] v;
    wr(A_IDX, 8'h01);
    wr(A_CTL, 8'h00); rd(A_CTL, v); chk("R3 dir rw", v, 8'h00);
    chk("R5 oe all out", pad_oe, 8'hFF);
    chk("R5 pad all out", pad_out, 8'hA5);
    wr(A_CTL, 8'hFF);
    chk("R6 oe all in", pad_oe, 8'h00);
    wr(A_CTL, 8'h0F); rd(A_CTL, v); chk("R3 dir split", v, 8'h0F);
    chk("R6 oe split", pad_oe, 8'hF0);
    chk("R5 pad split", pad_out & pad_oe, 8'hA0);
  endtask

  task automatic t_alt();
    logic [W-1:0] v, exp_oe, exp_out;
    af_out = 8'hFF; af_oe = 8'h0F;
    wr(A_IDX, 8'h02);
    wr(A_CTL, 8'h3C); rd(A_CTL, v); chk("R3 alt rw", v, 8'h3C);
    // alt bits 5..2 take af values; bits 7,6 outputs (dir 0), bits 1,0 inputs
    exp_oe  = 8'b1100_1100;
    exp_out = 8'b1011_1101;
    chk("R7 oe override", pad_oe, exp_oe);
    chk("R7 out override", pad_out, exp_out);
    wr(A_IDX, 8'h01); wr(A_CTL, 8'h00);
    chk("R7 dir ignored oe", pad_oe & 8'h3C, 8'h0C);
    wr(A_CTL, 8'h0F);
  endtask

  task automatic t_bad_idx();
    logic [W-1:0] v;
    wr(A_IDX, 8'h03); wr(A_CTL, 8'h55); rd(A_CTL, v); chk("R4 code 03 read", v, 8'h00);
    wr(A_IDX, 8'h00); wr(A_CTL, 8'hAA); rd(A_CTL, v); chk("R4 code 00 read", v, 8'h00);
    wr(A_IDX, 8'hFF); wr(A_CTL, 8'h00); rd(A_CTL, v); chk("R4 code FF read", v, 8'h00);
    sub_rd(8'h01, v); chk("R4 dir kept", v, 8'h0F);
    sub_rd(8'h02, v); chk("R4 alt kept", v, 8'h3C);
  endtask

  task automatic t_input();
    logic [W-1:0] v;
    @(negedge clk); pad_in = 8'hC3;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_IN;
    #1 chk("R8 not yet after 2", bus_rdata, 8'h00);
    @(posedge clk); @(negedge clk);
    #1 chk("R8 seen after 3", bus_rdata, 8'hC3);
    bus_sel = 1'b0;
  endtask

  task automatic t_readonly();
    logic [W-1:0] v;
    wr(A_IN, 8'h77);
    rd(A_IN, v); chk("R9 in unchanged", v, 8'hC3);
    rd(A_OUT, v); chk("R9 out kept", v, 8'hA5);
    rd(A_IDX, v); chk("R9 idx kept", v, 8'h02);
    rd(A_CTL, v); chk("R9 alt kept", v, 8'h3C);
    @(negedge clk); pad_in = 8'h18;
    repeat (3) @(posedge clk);
    rd(A_IN, v); chk("R9 still tracks pad", v, 8'h18);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_index();
    t_dir();
    t_alt();
    t_bad_idx();
    t_input();
    t_readonly();
    done = 1;
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end
endmodule